// File: doc/BRIEF.md
# Watchdog Timer with Protected Configuration

This block is a watchdog timer that counts ticks of a slow, separate oscillator. The tick is a one-cycle enable in the system clock domain. A 4-bit period code selects the time-out length through a multiplexer placed after the prescaler counter. When the counter expires, the block either raises a one-cycle system reset request or sets a sticky interrupt flag. Which one depends on the interrupt-mode bit. Software restarts the count with a kick strobe.

Software reaches the control state through a single write port that holds two registers. The first is a protection register: writing the unlock key to it opens a short window. The second is the control register, which carries the period code, the enable bit, the interrupt-mode bit and the interrupt flag. A static fuse input selects one of two safety levels:
- **Safety level 1 (fuse low):** the watchdog can be switched on freely, but switching it off needs the window.
- **Safety level 2 (fuse high):** the watchdog is always running, and changing its period or mode needs the window.

Top module: `wdt_guard`

## Requirements
- R1: After reset with the fuse low, `ctrl_rd` reads 0x00, and `rst_req` and `irq` are low. The control layout is: bits [3:0] period code, bit 4 enable, bit 5 interrupt mode, bit 6 interrupt flag, bit 7 reads zero.
- R2: Period code n gives a time-out of 2^(BASE_EXP+n) ticks. Codes above MAX_CODE (9) behave like code 9. With a tick every cycle, a clear at clock edge E is followed by `rst_req` high for exactly one cycle after edge E+2^(BASE_EXP+n).
- R3: With the fuse low, the enable bit can be set to one, and the period code changed, by a plain control write.
- R4: With the fuse low, writing enable=0 turns an enabled watchdog off only if the unlock window is open. Otherwise the enable bit stays 1. A disabled watchdog raises no reset request.
- R5: Writing 0xD8 to the protection register (`wr_sel`=0) opens the window for the next 4 clock edges. Any other value does not open it. The first control write (`wr_sel`=1) closes it.
- R6: With the fuse high, the watchdog runs from reset and enable always reads 1. A written enable value has no effect.
- R7: With the fuse high, the period code and the interrupt-mode bit change only on a control write made inside the window.
- R8: The prescaler counter restarts from zero on a `kick` strobe, and on any write that changes the period code or the enable bit.
- R9: In interrupt mode, a time-out sets the flag (bit 6) and drives `irq` high, with no reset request. The flag stays set until a control write with bit 6 = 1 clears it.
- R10: The counter advances only on cycles where `osc_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle tick from the watchdog oscillator |
| fuse_lvl2 | input | 1 | Static safety-level select, 1 = level 2 |
| kick | input | 1 | Watchdog restart strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = protection register, 1 = control register |
| wr_data | input | 8 | Write data |
| ctrl_rd | output | 8 | Control register read value |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Interrupt request (level, from the flag) |

## Verification
The time-out length is swept over all sixteen period codes with a tick on every cycle. This separates the correct exponent from an off-by-one error and shows that the reserved codes clamp to code 9. A half-rate tick pattern shows that the count follows ticks and not clock cycles. A run of periodic kicks, followed by a period change, checks each way the counter can be cleared.

The unlock window is tried in five ways:
- a wrong key;
- a write on the 4th edge after the key;
- a write on the 5th edge after the key;
- a second control write after a first one has used the window;
- under both fuse settings.

Together these show exactly where the protection boundaries lie.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
    localparam int PER_W   = 4;
    localparam int BIT_EN  = 4;
    localparam int BIT_IRQ = 5;
    localparam int BIT_FLG = 6;

    typedef struct packed {
        logic             en;
        logic             irqm;
        logic             flag;
        logic [PER_W-1:0] per;
        logic             rst_req;
    } wdt_state_t;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock #(
    parameter logic [7:0] SIG_VALUE  = 8'hD8,
    parameter int         WIN_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prot_wr,
    input  logic       ctrl_wr,
    input  logic [7:0] wr_data,
    output logic       win_open
);
    localparam int WW = $clog2(WIN_CYCLES + 1);

    logic [WW-1:0] cnt_d, cnt_q;
    logic          key_ok;

    assign key_ok   = prot_wr && (wr_data == SIG_VALUE);
    assign win_open = (cnt_q != '0);

    always_comb begin
        cnt_d = cnt_q;
        if (key_ok)
            cnt_d = WW'(WIN_CYCLES);
        else if (ctrl_wr)
            cnt_d = '0;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5: key opens, control write closes, nothing else opens
    p_key_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
        key_ok |=> win_open);
    p_ctrl_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !win_open);
    p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open && !key_ok) |=> !win_open);
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale
    import wdt_guard_pkg::*;
#(
    parameter int BASE_EXP = 11,
    parameter int MAX_CODE = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic             tick,
    input  logic [PER_W-1:0] per,
    output logic             expire
);
    localparam int CW   = BASE_EXP + MAX_CODE;
    localparam int NSEL = 1 << PER_W;

    logic [CW-1:0] lim_tab [NSEL];
    logic [CW-1:0] last;
    logic [CW-1:0] cnt_d, cnt_q;

    for (genvar g = 0; g < NSEL; g++) begin : g_lim
        localparam int EXP = BASE_EXP + ((g > MAX_CODE) ? MAX_CODE : g);
        assign lim_tab[g] = CW'((64'd1 << EXP) - 64'd1);
    end

    assign last   = lim_tab[per];
    assign expire = run && tick && !clear && (cnt_q == last);

    always_comb begin
        cnt_d = cnt_q;
        if (clear || !run || expire)
            cnt_d = '0;
        else if (tick)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: count never passes the selected limit
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last);
    // R10: no tick, no advance
    p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !clear) |=> $stable(cnt_q));
    // R8: clear returns to zero
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter logic [7:0] SIG_VALUE  = 8'hD8,
    parameter int         WIN_CYCLES = 4,
    parameter int         BASE_EXP   = 11,
    parameter int         MAX_CODE   = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       fuse_lvl2,
    input  logic       kick,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] ctrl_rd,
    output logic       rst_req,
    output logic       irq
);
    wdt_state_t       st_d, st_q;
    logic             prot_wr, ctrl_wr, win_open, expire, run, clear;
    logic             en_nxt, irqm_nxt;
    logic [PER_W-1:0] per_nxt;

    assign prot_wr = wr_en && !wr_sel;
    assign ctrl_wr = wr_en && wr_sel;
    assign run     = st_q.en || fuse_lvl2;

    wdt_unlock #(.SIG_VALUE(SIG_VALUE), .WIN_CYCLES(WIN_CYCLES)) u_unlock (
        .clk(clk), .rst_n(rst_n), .prot_wr(prot_wr), .ctrl_wr(ctrl_wr),
        .wr_data(wr_data), .win_open(win_open)
    );

    // configuration write decode per safety level
    always_comb begin
        en_nxt   = st_q.en;
        irqm_nxt = st_q.irqm;
        per_nxt  = st_q.per;
        if (ctrl_wr) begin
            if (!fuse_lvl2) begin
                per_nxt  = wr_data[PER_W-1:0];
                irqm_nxt = wr_data[BIT_IRQ];
                if (wr_data[BIT_EN])
                    en_nxt = 1'b1;
                else if (win_open)
                    en_nxt = 1'b0;
            end else if (win_open) begin
                per_nxt  = wr_data[PER_W-1:0];
                irqm_nxt = wr_data[BIT_IRQ];
            end
        end
    end

    assign clear = kick || (per_nxt != st_q.per) || (en_nxt != st_q.en);

    wdt_prescale #(.BASE_EXP(BASE_EXP), .MAX_CODE(MAX_CODE)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .clear(clear), .tick(osc_tick),
        .per(st_q.per), .expire(expire)
    );

    always_comb begin
        st_d         = st_q;
        st_d.en      = en_nxt;
        st_d.irqm    = irqm_nxt;
        st_d.per     = per_nxt;
        st_d.rst_req = 1'b0;
        if (ctrl_wr && wr_data[BIT_FLG])
            st_d.flag = 1'b0;
        if (expire) begin
            if (st_q.irqm) st_d.flag    = 1'b1;
            else           st_d.rst_req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_rd = {1'b0, st_q.flag, st_q.irqm, run, st_q.per};
    assign rst_req = st_q.rst_req;
    assign irq     = st_q.flag;

    // R6: level 2 always reports enabled
    p_lvl2_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_lvl2 |-> ctrl_rd[BIT_EN]);
    // R4: level 1 cannot be switched off outside the window
    p_l1_disable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fuse_lvl2 && st_q.en && !win_open) |=> st_q.en);
    // R7: level 2 period locked outside the window
    p_l2_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_lvl2 && !win_open) |=> $stable(st_q.per));
    // R9: interrupt mode never requests reset
    p_irq_no_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(st_q.irqm));
    // R2: reset request is a single-cycle pulse
    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
endmodule

// File: tb/tb_wdt_guard.sv
module tb_wdt_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b1;
    logic       fuse_lvl2 = 1'b0;
    logic       kick = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] ctrl_rd;
    logic       rst_req, irq;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;
    bit  half_tick = 1'b0;

    localparam int BEXP = 2;

    always #2 clk = ~clk;

    always @(negedge clk) osc_tick <= half_tick ? ~osc_tick : 1'b1;

    wdt_guard #(.BASE_EXP(BEXP)) dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .fuse_lvl2(fuse_lvl2),
        .kick(kick), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ctrl_rd(ctrl_rd), .rst_req(rst_req), .irq(irq)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(bit sel, logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_kick();
        kick = 1'b1;
        @(posedge clk); @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic measure(output int n);
        n = 0;
        while (n < 5000) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (rst_req) break;
        end
    endtask

    function automatic int tlen(int code);
        return 1 << (BEXP + ((code > 9) ? 9 : code));
    endfunction

    initial begin
        int n, seen;
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 ctrl", ctrl_rd, 8'h00);
        chk("R1 rst_req", rst_req, 0);
        chk("R1 irq", irq, 0);
        seen = 0;
        for (int i = 0; i < 50; i++) begin idle(1); if (rst_req) seen = 1; end
        chk("R1 disabled no reset", seen, 0);

        // R2/R3 sweep all period codes, each write changes code (clears)
        for (int c = 0; c < 16; c++) begin
            wr(1'b1, 8'h10 | 8'(c));
            chk("R3 enabled/period", ctrl_rd, 8'h10 | c);
            measure(n);
            chk($sformatf("R2 code %0d", c), n, tlen(c));
        end

        // R4 disable without window ignored
        wr(1'b1, 8'h0F);
        chk("R4 disable w/o window", ctrl_rd[4], 1);
        wr(1'b0, 8'hD8);
        wr(1'b1, 8'h00);
        chk("R4 disable in window", ctrl_rd, 8'h00);
        seen = 0;
        for (int i = 0; i < 3000; i++) begin idle(1); if (rst_req) seen = 1; end
        chk("R4 no reset when off", seen, 0);

        // R5 window rules
        wr(1'b1, 8'h13);
        wr(1'b0, 8'hD7); wr(1'b1, 8'h03);
        chk("R5 wrong key", ctrl_rd[4], 1);
        wr(1'b0, 8'hD8); idle(4); wr(1'b1, 8'h03);
        chk("R5 5th edge late", ctrl_rd[4], 1);
        wr(1'b0, 8'hD8); idle(3); wr(1'b1, 8'h03);
        chk("R5 4th edge ok", ctrl_rd[4], 0);
        wr(1'b1, 8'h13);
        wr(1'b0, 8'hD8); wr(1'b1, 8'h13); wr(1'b1, 8'h03);
        chk("R5 closed by first write", ctrl_rd[4], 1);

        // R8 kick keeps it alive, then times out from last kick
        do_kick();
        seen = 0;
        for (int k = 0; k < 5; k++) begin
            for (int i = 0; i < 20; i++) begin idle(1); if (rst_req) seen = 1; end
            do_kick();
        end
        chk("R8 kicked no reset", seen, 0);
        measure(n);
        chk("R8 time from kick", n, 32);
        idle(10);
        wr(1'b1, 8'h14);
        measure(n);
        chk("R8 period change clears", n, 64);

        // R10 half-rate ticks
        half_tick = 1'b1;
        wr(1'b1, 8'h13);
        measure(n);
        chk("R10 half-rate ticks", (n == 63 || n == 64) ? 1 : 0, 1);
        half_tick = 1'b0;
        idle(2);

        // R9 interrupt mode
        wr(1'b1, 8'h32);
        n = 0; seen = 0;
        while (n < 100 && !irq) begin
            @(posedge clk); n++; @(negedge clk);
            if (rst_req) seen = 1;
        end
        chk("R9 irq time", n, 16);
        chk("R9 no reset", seen, 0);
        idle(5);
        chk("R9 flag sticky", ctrl_rd[6], 1);
        wr(1'b1, 8'h72);
        chk("R9 w1c flag", ctrl_rd[6], 0);
        chk("R9 irq low", irq, 0);

        // R6/R7 safety level 2
        rst_n = 1'b0; fuse_lvl2 = 1'b1;
        idle(2);
        rst_n = 1'b1;
        chk("R6 enabled after reset", ctrl_rd, 8'h10);
        measure(n);
        chk("R6 runs from reset", n, 4);
        wr(1'b1, 8'h05);
        chk("R6 R7 locked", ctrl_rd, 8'h10);
        wr(1'b0, 8'hD8); wr(1'b1, 8'h05);
        chk("R7 period in window", ctrl_rd, 8'h15);
        measure(n);
        chk("R7 new period", n, 128);
        wr(1'b0, 8'hD8); wr(1'b1, 8'h25);
        chk("R7 irq mode in window", ctrl_rd & 8'hBF, 8'h35);
        wr(1'b1, 8'h05);
        chk("R7 irq mode locked", ctrl_rd & 8'hBF, 8'h35);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule